// File: doc/BRIEF.md
# On-Screen Display Command Stream Decoder

This block sits behind a two-wire serial slave front end that has already matched its device address. It interprets each following byte as one of three things: a row address, a column address, or a display character. For each character byte it issues one write to a character display memory. The front end supplies a byte strobe plus pulses marking the start and the stop of a bus transaction. The decoder returns to its idle, row-expecting condition on either pulse.

Two bits decide what a byte means while the decoder is expecting an address. Bit 7 set marks a row address, taken from bits [6:0]. Bit 7 clear marks a column address, taken from bits [5:0]. In a column byte, bit 6 picks the mode:
- With bit 6 clear, exactly one character byte follows, and the decoder then expects an address again. Either a new column (keeping the row) or a new row may come next.
- With bit 6 set, the decoder enters a burst mode that lasts to the end of the transaction. Every later byte is a character, and the write position advances by one column after each byte. It wraps from the last column to column 0 of the next row, and from the last row back to row 0.

Bytes arrive at serial bus speed, far below the system clock. Malformed addresses raise a one-cycle error pulse and are otherwise dropped.

Top module: `osd_cmd_decoder`

## Requirements
- R1: After reset, a start pulse or a stop pulse, the decoder accepts only a row address. A column byte (bit 7 = 0) that arrives before any valid row byte raises err_o and produces no write.
- R2: While an address is expected, a byte with bit 7 = 1 and bits [6:0] < NUM_ROWS sets the current row. It produces no write and no error.
- R3: A column byte with bit 7 = 0, bit 6 = 0 and bits [5:0] < NUM_COLS sets the current column. The next byte is then written as a character at that row and column, whatever its bit values.
- R4: After a character that follows a bit-6-clear column byte, the next byte is decoded again as an address. A column byte keeps the current row, and a row byte replaces it.
- R5: A valid column byte with bit 6 = 1 enters burst mode. Every later byte of the transaction is written as a character, even if bit 7 or bit 6 is set.
- R6: In burst mode, the position advances after each character. The column moves from NUM_COLS-1 to 0 and increments the row at the same time, and the row moves from NUM_ROWS-1 to 0.
- R7: A row byte with index >= NUM_ROWS or a column byte with index >= NUM_COLS raises err_o. The byte is ignored, and the current row, the current column and the decoding mode all stay as they were.
- R8: Each character byte gives exactly one wr_en_o pulse, one clock wide, in the cycle after its byte strobe. The pulse carries the row, the column and the byte value.
- R9: A stop or start pulse ends burst mode and any partly received address. The following byte must again be a row address.
- R10: err_o is a one-cycle pulse in the cycle after the offending byte strobe, and it never coincides with wr_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start_i | input | 1 | One-cycle pulse: a bus transaction has begun |
| xfer_stop_i | input | 1 | One-cycle pulse: a bus transaction has ended |
| byte_valid_i | input | 1 | One-cycle strobe: byte_i holds a received byte |
| byte_i | input | 8 | Received byte |
| wr_en_o | output | 1 | Character memory write strobe |
| wr_row_o | output | ROW_W | Row of the write |
| wr_col_o | output | COL_W | Column of the write |
| wr_data_o | output | 8 | Character code written |
| err_o | output | 1 | One-cycle protocol error pulse |

## Verification
A wrong decoding mode shows up on the very next byte. A byte taken as an address when it should have been a character makes wr_en_o stay low in the cycle where a write was due. The reverse mistake produces a write where none was due. A corrupted position register stays hidden until the next character write, and then shows as the wrong wr_row_o or wr_col_o in the cycle after that byte's strobe. The wrap behaviour of burst mode is therefore checked by driving bytes across both the last column and the last row. A clear that fails to take effect on stop or start shows up when the next column byte is written or accepted, where an error pulse was due.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;

  // Decoding mode of the stream
  typedef enum logic [1:0] {
    ST_ADDR  = 2'd0,   // next byte is a row or column address
    ST_INFO  = 2'd1,   // next byte is one character, then back to ST_ADDR
    ST_BURST = 2'd2    // every byte is a character until the transaction ends
  } dec_state_e;

  // Meaning assigned to the byte on the input
  typedef enum logic [1:0] {
    BK_INFO      = 2'd0,
    BK_ROW       = 2'd1,
    BK_COL_SINGLE = 2'd2,
    BK_COL_BURST = 2'd3
  } byte_kind_e;

  function automatic logic marks_row(input logic [7:0] b);
    return b[7];
  endfunction

  function automatic logic marks_burst(input logic [7:0] b);
    return b[6];
  endfunction

endpackage

// File: rtl/osd_cmd_classify.sv
module osd_cmd_classify
  import osd_cmd_pkg::*;
#(
  parameter int NUM_ROWS = 16,
  parameter int NUM_COLS = 40,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 6
) (
  input  dec_state_e          state_i,
  input  logic                row_valid_i,
  input  logic [7:0]          byte_i,
  output byte_kind_e          kind_o,
  output logic                bad_o,
  output logic [ROW_W-1:0]    row_idx_o,
  output logic [COL_W-1:0]    col_idx_o
);

  logic [6:0] row_field;
  logic [5:0] col_field;
  logic       row_in_range;
  logic       col_in_range;

  assign row_field    = byte_i[6:0];
  assign col_field    = byte_i[5:0];
  assign row_in_range = (32'(row_field) < NUM_ROWS);
  assign col_in_range = (32'(col_field) < NUM_COLS);
  assign row_idx_o    = ROW_W'(row_field);
  assign col_idx_o    = COL_W'(col_field);

  always_comb begin
    kind_o = BK_INFO;
    bad_o  = 1'b0;
    if (state_i == ST_ADDR) begin
      if (marks_row(byte_i)) begin
        kind_o = BK_ROW;
        bad_o  = !row_in_range;
      end else begin
        kind_o = marks_burst(byte_i) ? BK_COL_BURST : BK_COL_SINGLE;
        bad_o  = !row_valid_i || !col_in_range;
      end
    end
  end

endmodule

// File: rtl/osd_cmd_ctrl.sv
module osd_cmd_ctrl
  import osd_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_start_i,
  input  logic       xfer_stop_i,
  input  logic       byte_valid_i,
  input  byte_kind_e kind_i,
  input  logic       bad_i,
  output dec_state_e state_o,
  output logic       row_valid_o,
  output logic       load_row_o,
  output logic       load_col_o,
  output logic       write_o,
  output logic       step_o,
  output logic       err_o
);

  dec_state_e state_q, state_d;
  logic       row_valid_q, row_valid_d;
  logic       clear_ev;
  logic       byte_ev;

  assign clear_ev   = xfer_start_i || xfer_stop_i;
  assign byte_ev    = byte_valid_i && !clear_ev;

  assign load_row_o = byte_ev && (state_q == ST_ADDR) && (kind_i == BK_ROW) && !bad_i;
  assign load_col_o = byte_ev && (state_q == ST_ADDR) && !bad_i &&
                      ((kind_i == BK_COL_SINGLE) || (kind_i == BK_COL_BURST));
  assign write_o    = byte_ev && (state_q != ST_ADDR);
  assign step_o     = write_o && (state_q == ST_BURST);
  assign err_o      = byte_ev && bad_i;

  always_comb begin
    state_d     = state_q;
    row_valid_d = row_valid_q;
    if (clear_ev) begin
      state_d     = ST_ADDR;
      row_valid_d = 1'b0;
    end else if (load_row_o) begin
      row_valid_d = 1'b1;
    end else if (load_col_o) begin
      state_d = (kind_i == BK_COL_BURST) ? ST_BURST : ST_INFO;
    end else if (write_o && (state_q == ST_INFO)) begin
      state_d = ST_ADDR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_ADDR;
      row_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      row_valid_q <= row_valid_d;
    end
  end

  assign state_o     = state_q;
  assign row_valid_o = row_valid_q;

  // Burst mode persists until a transaction boundary
  p_burst_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BURST && !xfer_start_i && !xfer_stop_i) |=> (state_q == ST_BURST));

  // A rejected byte leaves the decoding mode untouched
  p_err_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (state_q == $past(state_q)) && (row_valid_q == $past(row_valid_q)));

  // A column is only accepted once a row is known
  p_col_needs_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_col_o |-> row_valid_q);

  // A boundary pulse always returns to row-expecting idle
  p_clear_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_ev |=> (state_q == ST_ADDR) && !row_valid_q);

endmodule

// File: rtl/osd_cmd_pos.sv
module osd_cmd_pos #(
  parameter int NUM_ROWS = 16,
  parameter int NUM_COLS = 40,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_row_i,
  input  logic             load_col_i,
  input  logic             step_i,
  input  logic [ROW_W-1:0] row_idx_i,
  input  logic [COL_W-1:0] col_idx_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);

  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             col_wraps;

  function automatic logic [COL_W-1:0] advance_col(input logic [COL_W-1:0] c);
    return (c == COL_LAST) ? '0 : c + COL_W'(1);
  endfunction

  function automatic logic [ROW_W-1:0] advance_row(input logic [ROW_W-1:0] r);
    return (r == ROW_LAST) ? '0 : r + ROW_W'(1);
  endfunction

  assign col_wraps = (col_q == COL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (load_row_i) row_q <= row_idx_i;
      else if (step_i && col_wraps) row_q <= advance_row(row_q);
      if (load_col_i) col_q <= col_idx_i;
      else if (step_i) col_q <= advance_col(col_q);
    end
  end

  assign row_o = row_q;
  assign col_o = col_q;

  p_col_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(col_q) < NUM_COLS);

  p_row_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(row_q) < NUM_ROWS);

  // A step off the last column lands on column zero
  p_col_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_col_i && col_wraps) |=> (col_q == '0));

endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
  import osd_cmd_pkg::*;
#(
  parameter int NUM_ROWS = 16,
  parameter int NUM_COLS = 40,
  localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start_i,
  input  logic             xfer_stop_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  output logic             wr_en_o,
  output logic [ROW_W-1:0] wr_row_o,
  output logic [COL_W-1:0] wr_col_o,
  output logic [7:0]       wr_data_o,
  output logic             err_o
);

  dec_state_e       state;
  byte_kind_e       kind;
  logic             row_valid;
  logic             bad;
  logic [ROW_W-1:0] row_idx;
  logic [COL_W-1:0] col_idx;
  logic             load_row_ev;
  logic             load_col_ev;
  logic             write_ev;
  logic             step_ev;
  logic             err_ev;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;

  osd_cmd_classify #(
    .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_classify (
    .state_i     (state),
    .row_valid_i (row_valid),
    .byte_i      (byte_i),
    .kind_o      (kind),
    .bad_o       (bad),
    .row_idx_o   (row_idx),
    .col_idx_o   (col_idx)
  );

  osd_cmd_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_start_i (xfer_start_i),
    .xfer_stop_i  (xfer_stop_i),
    .byte_valid_i (byte_valid_i),
    .kind_i       (kind),
    .bad_i        (bad),
    .state_o      (state),
    .row_valid_o  (row_valid),
    .load_row_o   (load_row_ev),
    .load_col_o   (load_col_ev),
    .write_o      (write_ev),
    .step_o       (step_ev),
    .err_o        (err_ev)
  );

  osd_cmd_pos #(
    .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_row_i (load_row_ev),
    .load_col_i (load_col_ev),
    .step_i     (step_ev),
    .row_idx_i  (row_idx),
    .col_idx_i  (col_idx),
    .row_o      (cur_row),
    .col_o      (cur_col)
  );

  // Registered memory write port: position before any burst advance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      wr_row_o  <= '0;
      wr_col_o  <= '0;
      wr_data_o <= '0;
      err_o     <= 1'b0;
    end else begin
      wr_en_o <= write_ev;
      err_o   <= err_ev;
      if (write_ev) begin
        wr_row_o  <= cur_row;
        wr_col_o  <= cur_col;
        wr_data_o <= byte_i;
      end
    end
  end

  p_write_after_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(byte_valid_i));

  p_err_after_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(byte_valid_i));

  p_err_not_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_o && wr_en_o));

  p_write_col_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (32'(wr_col_o) < NUM_COLS) && (32'(wr_row_o) < NUM_ROWS));

endmodule

// File: tb/osd_cmd_decoder_bench.sv
`timescale 1ns/1ps
module osd_cmd_decoder_bench;

  localparam int NR = 16;
  localparam int NC = 40;
  localparam int NV = 23;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xfer_start_i = 1'b0;
  logic       xfer_stop_i = 1'b0;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       wr_en_o;
  logic [3:0] wr_row_o;
  logic [5:0] wr_col_o;
  logic [7:0] wr_data_o;
  logic       err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  osd_cmd_decoder #(.NUM_ROWS(NR), .NUM_COLS(NC)) u_osd_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .xfer_start_i(xfer_start_i), .xfer_stop_i(xfer_stop_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .wr_en_o(wr_en_o),
    .wr_row_o(wr_row_o), .wr_col_o(wr_col_o), .wr_data_o(wr_data_o), .err_o(err_o)
  );

  // Vector: {op[1:0] (0 byte, 1 stop), byte, exp_wr, exp_err, exp_row, exp_col, req}
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 8'h05, 1'b0, 1'b1, 8'd0,  8'd0,  4'd1},  // R1 column before row
    {2'd0, 8'h83, 1'b0, 1'b0, 8'd0,  8'd0,  4'd2},  // R2 row 3
    {2'd0, 8'h05, 1'b0, 1'b0, 8'd0,  8'd0,  4'd3},  // R3 column 5 single
    {2'd0, 8'h41, 1'b1, 1'b0, 8'd3,  8'd5,  4'd3},  // R3 character
    {2'd0, 8'h07, 1'b0, 1'b0, 8'd0,  8'd0,  4'd4},  // R4 new column only
    {2'd0, 8'hC2, 1'b1, 1'b0, 8'd3,  8'd7,  4'd4},  // R4 character, MSB set
    {2'd0, 8'h82, 1'b0, 1'b0, 8'd0,  8'd0,  4'd4},  // R4 new row 2
    {2'd0, 8'h00, 1'b0, 1'b0, 8'd0,  8'd0,  4'd4},  // R4 column 0
    {2'd0, 8'h10, 1'b1, 1'b0, 8'd2,  8'd0,  4'd4},  // R4 character
    {2'd0, 8'h94, 1'b0, 1'b1, 8'd0,  8'd0,  4'd7},  // R7 row 20 out of range
    {2'd0, 8'h32, 1'b0, 1'b1, 8'd0,  8'd0,  4'd7},  // R7 column 50 out of range
    {2'd0, 8'h01, 1'b0, 1'b0, 8'd0,  8'd0,  4'd7},  // R7 still expecting address
    {2'd0, 8'h55, 1'b1, 1'b0, 8'd2,  8'd1,  4'd7},  // R7 row kept at 2
    {2'd1, 8'h00, 1'b0, 1'b0, 8'd0,  8'd0,  4'd9},  // R9 stop
    {2'd0, 8'h03, 1'b0, 1'b1, 8'd0,  8'd0,  4'd9},  // R9 column after stop
    {2'd0, 8'h8F, 1'b0, 1'b0, 8'd0,  8'd0,  4'd2},  // R2 row 15
    {2'd0, 8'h66, 1'b0, 1'b0, 8'd0,  8'd0,  4'd5},  // R5 burst column 38
    {2'd0, 8'h80, 1'b1, 1'b0, 8'd15, 8'd38, 4'd5},  // R5 MSB set is data
    {2'd0, 8'h45, 1'b1, 1'b0, 8'd15, 8'd39, 4'd6},  // R6 advance
    {2'd0, 8'h00, 1'b1, 1'b0, 8'd0,  8'd0,  4'd6},  // R6 column and row wrap
    {2'd0, 8'hFF, 1'b1, 1'b0, 8'd0,  8'd1,  4'd8},  // R8 write value
    {2'd1, 8'h00, 1'b0, 1'b0, 8'd0,  8'd0,  4'd9},  // R9 stop ends burst
    {2'd0, 8'h11, 1'b0, 1'b1, 8'd0,  8'd0,  4'd9}   // R9 burst gone
  };

  task automatic check(input bit ok, input int req, input string what, input string got, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: got %s expected %s", req, what, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit ewr, input bit eerr,
                      input int erow, input int ecol, input int req);
    @(negedge clk);
    byte_valid_i = 1'b1;
    byte_i = b;
    @(negedge clk);
    byte_valid_i = 1'b0;
    check((wr_en_o == ewr) && (err_o == eerr) &&
          (!ewr || (int'(wr_row_o) == erow && int'(wr_col_o) == ecol && wr_data_o == b)),
          req, $sformatf("byte %02h", b),
          $sformatf("wr=%0b err=%0b row=%0d col=%0d data=%02h", wr_en_o, err_o, wr_row_o, wr_col_o, wr_data_o),
          $sformatf("wr=%0b err=%0b row=%0d col=%0d data=%02h", ewr, eerr, erow, ecol, b));
    @(negedge clk);
    check(!wr_en_o && !err_o, 8, "pulse width (R8/R10 one cycle)",
          $sformatf("wr=%0b err=%0b", wr_en_o, err_o), "wr=0 err=0");
  endtask

  task automatic pulse(input bit is_start);
    @(negedge clk);
    if (is_start) xfer_start_i = 1'b1; else xfer_stop_i = 1'b1;
    @(negedge clk);
    xfer_start_i = 1'b0;
    xfer_stop_i = 1'b0;
    check(!wr_en_o && !err_o, 9, "boundary pulse quiet",
          $sformatf("wr=%0b err=%0b", wr_en_o, err_o), "wr=0 err=0");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!wr_en_o && !err_o, 1, "reset outputs",
          $sformatf("wr=%0b err=%0b", wr_en_o, err_o), "wr=0 err=0");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][31:30] == 2'd1) pulse(1'b0);
      else send(VEC[i][29:22], VEC[i][21], VEC[i][20], int'(VEC[i][19:12]),
                int'(VEC[i][11:4]), int'(VEC[i][3:0]));
    end

    // R9 start pulse also ends burst mode
    send(8'h81, 1'b0, 1'b0, 0, 0, 9);
    send(8'h42, 1'b0, 1'b0, 0, 0, 9);
    send(8'hA5, 1'b1, 1'b0, 1, 2, 9);
    pulse(1'b1);
    send(8'h04, 1'b0, 1'b1, 0, 0, 9);
    // R3 single character after restart, then back to address (R4)
    send(8'h81, 1'b0, 1'b0, 0, 0, 3);
    send(8'h02, 1'b0, 1'b0, 0, 0, 3);
    send(8'h33, 1'b1, 1'b0, 1, 2, 3);
    send(8'h27, 1'b0, 1'b0, 0, 0, 4);
    send(8'h9A, 1'b1, 1'b0, 1, 39, 4);
    // R7 out-of-range burst column does not enter burst
    send(8'h7F, 1'b0, 1'b1, 0, 0, 7);
    send(8'h01, 1'b0, 1'b0, 0, 0, 7);
    send(8'h66, 1'b1, 1'b0, 1, 1, 7);

    // R1 reset in the middle of burst mode
    send(8'h80, 1'b0, 1'b0, 0, 0, 1);
    send(8'h40, 1'b0, 1'b0, 0, 0, 1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!wr_en_o && !err_o, 1, "reset mid burst",
          $sformatf("wr=%0b err=%0b", wr_en_o, err_o), "wr=0 err=0");
    rst_n = 1'b1;
    send(8'h00, 1'b0, 1'b1, 0, 0, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule